// File: doc/BRIEF.md
# Input Capture Channel with Edge Prescaler

This block timestamps transitions on an asynchronous input pin. The pin is brought into the system clock domain by a two-flop synchronizer and compared with its previous synchronized value to find rising and falling edges. A mode field picks which edges count: every edge, only falling edges, only rising edges, or every 4th or every 16th rising edge.

On each qualifying event the block stores one of two 16-bit free-running timer values, picked by a select bit, in a four-entry first-word-fall-through FIFO. Software reads the FIFO through a read strobe. A not-empty flag and an overflow flag report the FIFO state. An interrupt interval field sets how many capture events occur between one-cycle interrupt pulses.

Switching the channel off flushes all of its state. The timers, the bus decoding and the interrupt controller sit outside the block.

Top module: `icap_channel`

## Requirements
- R1: A pin change set up before clock edge k is detected in the cycle between edges k+1 and k+2. Its FIFO entry appears after edge k+2 and holds the timer value present in that detection cycle.
- R2: The mode field `modeSel` selects which edges are captured. Code 3'b001 captures every edge, 3'b010 every falling edge and 3'b011 every rising edge.
- R3: Code 3'b100 captures on every 4th rising edge and code 3'b101 on every 16th rising edge. The rising edges between captures are counted but store nothing.
- R4: Codes 3'b000, 3'b110 and 3'b111 turn the channel off. While off, nothing is captured, and one cycle later the FIFO is empty, the overflow flag is clear, no interrupt pulse is given, and both the prescaler count and the interrupt event count are zero.
- R5: In any cycle where `modeSel` differs from its value in the previous cycle, the prescaler count is cleared and any edge detected in that cycle is discarded.
- R6: With `timerSel`=0 the stored value comes from `timerA`; with `timerSel`=1 it comes from `timerB`.
- R7: The FIFO holds 4 entries in arrival order. `rdData` shows the oldest entry while `bufNotEmpty` is 1. `rdStb` removes that entry at the next clock edge and is ignored when the FIFO is empty. A capture and a read in the same cycle are both performed.
- R8: A capture into a full FIFO in a cycle without a read drops the new value and sets `overflow`. `overflow` stays set until a read leaves the FIFO empty, or until the channel is turned off.
- R9: With `irqInterval`=n, `irqPulse` is high for one cycle after every (n+1)th capture event. The pulse appears on the same edge as the FIFO write. Capture events dropped by an overflow still count.
- R10: After reset the FIFO is empty, `overflow` and `irqPulse` are 0, and the synchronizer, prescaler and interrupt counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Asynchronous capture input |
| timerA | input | 16 | First timer count |
| timerB | input | 16 | Second timer count |
| modeSel | input | 3 | Capture mode code |
| timerSel | input | 1 | Timer source select (0 = timerA, 1 = timerB) |
| irqInterval | input | 2 | Capture events per interrupt, minus one |
| rdStb | input | 1 | Pop the oldest FIFO entry |
| rdData | output | 16 | Oldest FIFO entry |
| bufNotEmpty | output | 1 | FIFO holds at least one entry |
| overflow | output | 1 | A capture was lost to a full FIFO |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check these on every cycle:
- an off mode empties the FIFO, clears overflow and suppresses interrupts;
- overflow only rises from a full FIFO;
- a lone read lowers the fill level by one;
- the level never exceeds the depth;
- an interrupt pulse always has data behind it.

Other behaviour only the bench's scenarios can show:
- the exact detection latency;
- which timer word is stored;
- prescaler counting of the 4th and 16th edge;
- edge discard on a mode change;
- the interrupt interval.

The bench compares these against a cycle model under both directed pulse trains and random pin, mode and read activity.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_BOTH   = 3'd1,
    MODE_FALL   = 3'd2,
    MODE_RISE   = 3'd3,
    MODE_RISE4  = 3'd4,
    MODE_RISE16 = 3'd5,
    MODE_RSV6   = 3'd6,
    MODE_RSV7   = 3'd7
  } capMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic flush;
  } capStb_t;

endpackage

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16,
  parameter int IRQ_W       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic [2:0]       modeSel,
  input  logic [IRQ_W-1:0] irqInterval,
  output capStb_t          stb,
  output logic             irqPulse
);

  localparam int PW = $clog2(DIV_HI);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinS, pinPrev;
  logic [2:0]             modePrev;
  logic [PW-1:0]          preCnt, preLimit;
  logic [IRQ_W-1:0]       irqCnt;
  logic                   rise, fall, edgeHit, modeOff, modeChg, preDone, capture;

  // synchronizer chain followed by a previous-value register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pinIn};
      pinPrev <= pinS;
    end
  end

  assign pinS = syncQ[SYNC_STAGES-1];
  assign rise = pinS & ~pinPrev;
  assign fall = ~pinS & pinPrev;

  always_comb begin
    modeOff  = 1'b0;
    edgeHit  = 1'b0;
    preLimit = '0;
    case (capMode_e'(modeSel))
      MODE_BOTH:   edgeHit = rise | fall;
      MODE_FALL:   edgeHit = fall;
      MODE_RISE:   edgeHit = rise;
      MODE_RISE4: begin
        edgeHit  = rise;
        preLimit = PW'(DIV_LO - 1);
      end
      MODE_RISE16: begin
        edgeHit  = rise;
        preLimit = PW'(DIV_HI - 1);
      end
      default:     modeOff = 1'b1;
    endcase
  end

  assign modeChg = (modeSel != modePrev);
  assign preDone = (preCnt == preLimit);
  assign capture = ~modeOff & ~modeChg & edgeHit & preDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev <= 3'd0;
      preCnt   <= '0;
    end else begin
      modePrev <= modeSel;
      if (modeOff || modeChg)
        preCnt <= '0;
      else if (edgeHit)
        preCnt <= preDone ? '0 : preCnt + 1'b1;
    end
  end

  // interrupt interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqCnt   <= '0;
      irqPulse <= 1'b0;
    end else if (modeOff) begin
      irqCnt   <= '0;
      irqPulse <= 1'b0;
    end else if (capture) begin
      if (irqCnt >= irqInterval) begin
        irqCnt   <= '0;
        irqPulse <= 1'b1;
      end else begin
        irqCnt   <= irqCnt + 1'b1;
        irqPulse <= 1'b0;
      end
    end else begin
      irqPulse <= 1'b0;
    end
  end

  assign stb.capture = capture;
  assign stb.flush   = modeOff;

endmodule

// File: rtl/icap_dpath.sv
module icap_dpath
  import icap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  capStb_t                      stb,
  input  logic [DATA_W-1:0]            timerA,
  input  logic [DATA_W-1:0]            timerB,
  input  logic                         timerSel,
  input  logic                         rdStb,
  output logic [DATA_W-1:0]            rdData,
  output logic                         bufNotEmpty,
  output logic                         overflow,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] stamp;
  logic              isFull, doPush, doPop;

  assign stamp   = timerSel ? timerB : timerA;
  assign isFull  = (count == CW'(DEPTH));
  assign doPop   = rdStb && (count != '0);
  assign doPush  = stb.capture && (!isFull || doPop);

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !stb.flush)
      mem[wrPtr] <= stamp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (stb.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (stb.capture && isFull && !doPop)
        overflow <= 1'b1;
      else if (doPop && !doPush && count == CW'(1))
        overflow <= 1'b0;
    end
  end

  assign rdData      = mem[rdPtr];
  assign bufNotEmpty = (count != '0);
  assign level       = count;

endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int TIMER_W    = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int IRQ_W      = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinIn,
  input  logic [TIMER_W-1:0] timerA,
  input  logic [TIMER_W-1:0] timerB,
  input  logic [2:0]         modeSel,
  input  logic               timerSel,
  input  logic [IRQ_W-1:0]   irqInterval,
  input  logic               rdStb,
  output logic [TIMER_W-1:0] rdData,
  output logic               bufNotEmpty,
  output logic               overflow,
  output logic               irqPulse
);

  localparam int LW = $clog2(FIFO_DEPTH + 1);

  capStb_t       ctrlStb;
  logic [LW-1:0] fifoLevel;

  icap_ctrl #(
    .SYNC_STAGES(2), .DIV_LO(4), .DIV_HI(16), .IRQ_W(IRQ_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .modeSel(modeSel),
    .irqInterval(irqInterval), .stb(ctrlStb), .irqPulse(irqPulse)
  );

  icap_dpath #(
    .DATA_W(TIMER_W), .DEPTH(FIFO_DEPTH)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .timerA(timerA),
    .timerB(timerB), .timerSel(timerSel), .rdStb(rdStb),
    .rdData(rdData), .bufNotEmpty(bufNotEmpty), .overflow(overflow),
    .level(fifoLevel)
  );

endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk
  import icap_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [2:0]                 modeSel,
  input logic                       rdStb,
  input logic                       bufNotEmpty,
  input logic                       overflow,
  input logic                       irqPulse,
  input logic [$clog2(DEPTH+1)-1:0] fifoLevel,
  input capStb_t                    stb
);

  localparam int CW = $clog2(DEPTH + 1);

  logic offCode;
  assign offCode = (modeSel == 3'd0) || (modeSel == 3'd6) || (modeSel == 3'd7);

  AST_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    offCode |=> (fifoLevel == '0 && !overflow && !bufNotEmpty)); // R4

  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    offCode |=> !irqPulse); // R4

  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> bufNotEmpty); // R9

  AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(fifoLevel) == CW'(DEPTH)); // R8

  AST_POP_DECR: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && bufNotEmpty && !stb.capture && !stb.flush)
      |=> fifoLevel == $past(fifoLevel) - CW'(1)); // R7

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= CW'(DEPTH)); // R7

endmodule

bind icap_channel icap_channel_chk #(.DEPTH(FIFO_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .rdStb(rdStb),
  .bufNotEmpty(bufNotEmpty), .overflow(overflow), .irqPulse(irqPulse),
  .fifoLevel(fifoLevel), .stb(ctrlStb)
);

// File: tb/icap_channel_bench.sv
module icap_channel_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pinIn;
  logic [15:0] timerA, timerB;
  logic [2:0]  modeSel;
  logic        timerSel;
  logic [1:0]  irqInterval;
  logic        rdStb;
  logic [15:0] rdData;
  logic        bufNotEmpty, overflow, irqPulse;

  always #5 clk = ~clk;

  icap_channel u_icap_channel (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .timerA(timerA), .timerB(timerB),
    .modeSel(modeSel), .timerSel(timerSel), .irqInterval(irqInterval),
    .rdStb(rdStb), .rdData(rdData), .bufNotEmpty(bufNotEmpty),
    .overflow(overflow), .irqPulse(irqPulse)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 1'b0;
  bit    running = 1'b0;
  string phase   = "R10";

  // reference model state
  logic        m1, m2, mp;
  logic [2:0]  mPrevMode;
  int          mPre, mIrqCnt;
  logic        mIrq, mOvf;
  logic [15:0] mQ[$];

  function automatic bit isOff(input logic [2:0] m);
    return (m == 3'd0) || (m >= 3'd6);
  endfunction

  function automatic int preLim(input logic [2:0] m);
    return (m == 3'd4) ? 3 : (m == 3'd5) ? 15 : 0;
  endfunction

  function automatic bit edgeOf(input logic [2:0] m, input logic cur, input logic prv);
    case (m)
      3'd1:         return cur != prv;
      3'd2:         return !cur && prv;
      3'd3, 3'd4,
      3'd5:         return cur && !prv;
      default:      return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 = 0; m2 = 0; mp = 0; mPrevMode = 3'd0;
      mPre = 0; mIrqCnt = 0; mIrq = 0; mOvf = 0;
      mQ.delete();
    end else begin
      bit off, chg, hit, cap, pop, full;
      int oldSize;
      off = isOff(modeSel);
      chg = (modeSel != mPrevMode);
      hit = edgeOf(modeSel, m2, mp);
      cap = !off && !chg && hit && (mPre == preLim(modeSel));
      oldSize = mQ.size();
      pop  = rdStb && (oldSize > 0);
      full = (oldSize == 4);
      if (off) begin
        mQ.delete(); mOvf = 0; mIrq = 0; mIrqCnt = 0;
      end else begin
        if (pop) void'(mQ.pop_front());
        if (cap) begin
          if (!full || pop) mQ.push_back(timerSel ? timerB : timerA);
          else mOvf = 1;
        end
        if (pop && !cap && oldSize == 1) mOvf = 0;
        if (cap) begin
          if (mIrqCnt >= int'(irqInterval)) begin mIrq = 1; mIrqCnt = 0; end
          else begin mIrq = 0; mIrqCnt++; end
        end else mIrq = 0;
      end
      if (off || chg) mPre = 0;
      else if (hit) mPre = (mPre == preLim(modeSel)) ? 0 : mPre + 1;
      mPrevMode = modeSel;
      mp = m2; m2 = m1; m1 = pinIn;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t: actual %h expected %h", tag, phase, $time, act, exp);
    end
  endtask

  // model comparison away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      check("R7 bufNotEmpty", 32'(bufNotEmpty), 32'(mQ.size() > 0));
      check("R8 overflow", 32'(overflow), 32'(mOvf));
      check("R9 irqPulse", 32'(irqPulse), 32'(mIrq));
      if (mQ.size() > 0) check("R6 rdData", 32'(rdData), 32'(mQ[0]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      timerA = timerA + 16'd1;
      timerB = timerB - 16'd3;
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    pinIn = 1'b1; cyc(hi);
    pinIn = 1'b0; cyc(lo);
  endtask

  task automatic drain();
    while (bufNotEmpty) begin rdStb = 1'b1; cyc(1); end
    rdStb = 1'b0; cyc(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1CAB7E55));
    rstN = 0; pinIn = 0; timerA = 16'h1000; timerB = 16'hF000;
    modeSel = 3'd3; timerSel = 0; irqInterval = 2'd0; rdStb = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 bufNotEmpty", 32'(bufNotEmpty), 0);
    check("R10 overflow", 32'(overflow), 0);
    check("R10 irqPulse", 32'(irqPulse), 0);
    rstN = 1;
    running = 1;
    cyc(3);

    // R1: detection latency in rising mode
    phase = "R1";
    pinIn = 1'b1; cyc(1);
    check("R1 empty after 1 edge", 32'(bufNotEmpty), 0);
    cyc(1);
    check("R1 empty after 2 edges", 32'(bufNotEmpty), 0);
    cyc(1);
    check("R1 stored after 3 edges", 32'(bufNotEmpty), 1);
    pinIn = 1'b0; cyc(4);
    drain();

    // R2: every edge, then falling only
    phase = "R2";
    modeSel = 3'd1; cyc(2);
    pulse(3, 3);
    check("R2 both edges gives two entries", 32'(mQ.size()), 2);
    drain();
    modeSel = 3'd2; cyc(2);
    pulse(3, 3); pulse(3, 3);
    drain();

    // R3: every 4th and every 16th rising edge
    phase = "R3";
    modeSel = 3'd4; cyc(2);
    repeat (3) pulse(3, 3);
    check("R3 no entry after 3 rises", 32'(bufNotEmpty), 0);
    pulse(3, 3);
    check("R3 entry after 4th rise", 32'(bufNotEmpty), 1);
    drain();
    modeSel = 3'd5; cyc(2);
    repeat (15) pulse(2, 2);
    check("R3 no entry after 15 rises", 32'(bufNotEmpty), 0);
    pulse(2, 3);
    check("R3 entry after 16th rise", 32'(bufNotEmpty), 1);
    drain();

    // R6: second timer source
    phase = "R6";
    modeSel = 3'd3; timerSel = 1; cyc(2);
    pulse(3, 3);
    timerSel = 0;
    drain();

    // R8: overflow and its release
    phase = "R8";
    repeat (6) pulse(2, 2);
    check("R8 overflow after 6 captures", 32'(overflow), 1);
    drain();
    check("R8 overflow cleared by empty read", 32'(overflow), 0);

    // R9: interval of 3 captures
    phase = "R9";
    irqInterval = 2'd2;
    repeat (7) begin pulse(2, 2); rdStb = 1; cyc(1); rdStb = 0; end
    irqInterval = 2'd0;

    // R4: reserved code turns channel off and flushes
    phase = "R4";
    repeat (3) pulse(2, 2);
    modeSel = 3'd6; cyc(1);
    check("R4 flushed by off code", 32'(bufNotEmpty), 0);
    pulse(2, 2);
    check("R4 no capture while off", 32'(bufNotEmpty), 0);
    modeSel = 3'd3; cyc(2);

    // R5: mode switches while pulsing
    phase = "R5";
    for (int i = 0; i < 40; i++) begin
      modeSel = (i % 3 == 0) ? 3'd4 : 3'd3;
      pinIn = ~pinIn; cyc(1 + (i % 3));
    end
    drain();

    // R7: constrained random traffic
    phase = "R7";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 3) == 0) pinIn = ~pinIn;
      if ($urandom_range(0, 199) == 0) modeSel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 99) == 0) irqInterval = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 49) == 0) timerSel = ~timerSel;
      rdStb = ($urandom_range(0, 4) == 0);
      timerA = 16'($urandom);
      timerB = 16'($urandom);
      @(negedge clk);
    end
    rdStb = 0;
    cyc(4);

    running = 0;
    done = 1;
    summary();
    $finish;
  end

endmodule